// File: doc/BRIEF.md
# Single-Bus Datapath With Hardwired Step Sequencer

This block is a small processor core in which every register transfer uses one shared internal bus. It holds a program counter, an instruction register, four general registers, a Y operand register, a Z result register, a memory address register and a memory data register. An adder takes its B operand from the bus. Its A operand comes from a multiplexer that picks either a fixed increment of 4 or the Y register. Each register has a load enable that captures the bus on the clock edge and an output enable that places the register on the bus.

A step counter decodes each step into control signals. Every instruction begins with a three-step fetch. Opcode 0 is an indirect add, which adds the memory word addressed by R3 into R1. Opcode 1 is a branch relative to the PC. Memory is reached through an address output, a request flag and a completion input. A step that waits for memory holds the counter until the completion input arrives. The final step of each instruction returns the counter to step 1 and produces a one-cycle `instr_done` pulse.

Top module: `sbus_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals `PC_RESET`, `gpr_o` equals `GPR_INIT`, and `mem_req` and `instr_done` are 0.
- R2: In any step, at most one source drives the shared bus.
- R3: Fetch loads the word at the current PC into IR and adds 4 to PC. The opcode is IR[31:28].
- R4: Opcode 0 adds the memory word at address R3 into R1. With single-cycle memory it takes 7 cycles.
- R5: Opcode 1 sets PC to the incremented PC plus the sign-extended offset in IR[15:0]. With single-cycle memory it takes 5 cycles.
- R6: Any other opcode only performs the fetch. It takes 4 cycles, and its final step does nothing.
- R7: A step that waits for memory holds the step counter until `mem_done` is 1. Each cycle of latency beyond one adds exactly one cycle to the instruction.
- R8: A read raises `mem_req` in the cycle after the read step, with `mem_addr` holding the address. `mem_req` stays high up to and including the cycle in which `mem_done` is 1, and then falls.
- R9: `instr_done` is high for exactly one cycle, in the cycle after the final step. The architectural registers already show that instruction's results in that cycle.
- R10: R0, R2 and R3 are never written. IR changes only during fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | W | Read address (memory address register) |
| mem_req | output | 1 | Read outstanding |
| mem_rdata | input | W | Read data, valid together with `mem_done` |
| mem_done | input | 1 | Memory completion |
| instr_done | output | 1 | One-cycle pulse after each instruction completes |
| pc_o | output | W | Program counter |
| ir_o | output | W | Instruction register |
| gpr_o | output | 4*W | General registers, R0 in the lowest W bits |

## Verification
The bench's memory model cycles through response latencies of 1, 4, 3 and 2 cycles, so every wait step is stretched by a different amount. A counter that ignored completion would load stale MDR data, which shows up as a wrong IR or a wrong sum in R1, together with a wrong cycle count. The program mixes a forward branch, a backward branch with a negative offset, and an unknown opcode. A mistake in sign extension or in decoding sends PC to the wrong address. The bench also checks that R0, R2 and R3 keep their initial values and that `instr_done` never stays high for two cycles. A design with bus contention or a misrouted load enable would corrupt one of these.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   localparam int NREG = 4;
   localparam logic [3:0] OP_ADD_IND = 4'd0;
   localparam logic [3:0] OP_BR_REL  = 4'd1;

   typedef struct packed {
      logic            pc_out;
      logic            pc_in;
      logic            mar_in;
      logic            rd;
      logic            sel4;
      logic            zin;
      logic            zout;
      logic            yin;
      logic            mdr_out;
      logic            ir_in;
      logic            off_out;
      logic            wmfc;
      logic            fin;
      logic [NREG-1:0] g_out;
      logic [NREG-1:0] g_in;
   } ctl_t;
endpackage

// File: rtl/sb_reg.sv
module sb_reg #(
   parameter int          W   = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST;
      else if (ld) q <= d;
   end

   // R10: a register without its load enable keeps its value
   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));
endmodule

// File: rtl/sb_alu.sv
module sb_alu #(
   parameter int W   = 32,
   parameter int INC = 4
) (
   input  logic         sel_inc,
   input  logic [W-1:0] y,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   localparam logic [W-1:0] INC_V = W'(INC);
   logic [W-1:0] a_mux;

   always_comb begin
      a_mux = sel_inc ? INC_V : y;
      sum   = a_mux + b;
   end
endmodule

// File: rtl/sb_seq.sv
module sb_seq
   import sbus_pkg::*;
#(
   parameter int PTR_IDX = 3,
   parameter int ACC_IDX = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] opcode,
   input  logic       mem_done,
   output ctl_t       ctl,
   output logic       instr_done
);
   logic [2:0] step;

   always_comb begin
      ctl = '0;
      unique case (step)
         3'd1: begin
            ctl.pc_out = 1'b1; ctl.mar_in = 1'b1; ctl.rd = 1'b1;
            ctl.sel4 = 1'b1; ctl.zin = 1'b1;
         end
         3'd2: begin
            ctl.zout = 1'b1; ctl.pc_in = 1'b1; ctl.yin = 1'b1; ctl.wmfc = 1'b1;
         end
         3'd3: begin
            ctl.mdr_out = 1'b1; ctl.ir_in = 1'b1;
         end
         3'd4: begin
            if (opcode == OP_ADD_IND) begin
               ctl.g_out[PTR_IDX] = 1'b1; ctl.mar_in = 1'b1; ctl.rd = 1'b1;
            end else if (opcode == OP_BR_REL) begin
               ctl.off_out = 1'b1; ctl.zin = 1'b1;
            end else begin
               ctl.fin = 1'b1;
            end
         end
         3'd5: begin
            if (opcode == OP_ADD_IND) begin
               ctl.g_out[ACC_IDX] = 1'b1; ctl.yin = 1'b1; ctl.wmfc = 1'b1;
            end else begin
               ctl.zout = 1'b1; ctl.pc_in = 1'b1; ctl.fin = 1'b1;
            end
         end
         3'd6: begin
            ctl.mdr_out = 1'b1; ctl.zin = 1'b1;
         end
         3'd7: begin
            ctl.zout = 1'b1; ctl.g_in[ACC_IDX] = 1'b1; ctl.fin = 1'b1;
         end
         default: ctl.fin = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step       <= 3'd1;
         instr_done <= 1'b0;
      end else begin
         instr_done <= ctl.fin;
         if (ctl.fin)                   step <= 3'd1;
         else if (ctl.wmfc && !mem_done) step <= step;
         else                           step <= step + 3'd1;
      end
   end

   p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.wmfc && !mem_done && !ctl.fin) |=> $stable(step));
   p_end_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.fin |=> (step == 3'd1));
endmodule

// File: rtl/sbus_core.sv
module sbus_core
   import sbus_pkg::*;
#(
   parameter int                  W        = 32,
   parameter logic [W-1:0]        PC_RESET = '0,
   parameter logic [NREG*W-1:0]   GPR_INIT = '0,
   parameter int                  PTR_IDX  = 3,
   parameter int                  ACC_IDX  = 1,
   parameter int                  INC      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [W-1:0]      mem_addr,
   output logic              mem_req,
   input  logic [W-1:0]      mem_rdata,
   input  logic              mem_done,
   output logic              instr_done,
   output logic [W-1:0]      pc_o,
   output logic [W-1:0]      ir_o,
   output logic [NREG*W-1:0] gpr_o
);
   localparam int OFF_W = 16;

   if (W < 32) begin : g_bad_width
      $error("sbus_core: W must be at least 32");
   end
   if (PTR_IDX >= NREG || ACC_IDX >= NREG) begin : g_bad_idx
      $error("sbus_core: register index out of range");
   end

   ctl_t         ctl;
   logic [W-1:0] bus, pc, ir, y, z, mar, mdr, sum, off_x;
   logic [W-1:0] gpr [NREG];
   logic         pend;

   sb_seq #(.PTR_IDX(PTR_IDX), .ACC_IDX(ACC_IDX)) u_seq (
      .clk(clk), .rst_n(rst_n), .opcode(ir[31:28]), .mem_done(mem_done),
      .ctl(ctl), .instr_done(instr_done));

   sb_alu #(.W(W), .INC(INC)) u_alu (
      .sel_inc(ctl.sel4), .y(y), .b(bus), .sum(sum));

   sb_reg #(.W(W), .RST(PC_RESET)) u_pc (
      .clk(clk), .rst_n(rst_n), .ld(ctl.pc_in), .d(bus), .q(pc));
   sb_reg #(.W(W)) u_ir (
      .clk(clk), .rst_n(rst_n), .ld(ctl.ir_in), .d(bus), .q(ir));
   sb_reg #(.W(W)) u_y (
      .clk(clk), .rst_n(rst_n), .ld(ctl.yin), .d(bus), .q(y));
   sb_reg #(.W(W)) u_z (
      .clk(clk), .rst_n(rst_n), .ld(ctl.zin), .d(sum), .q(z));
   sb_reg #(.W(W)) u_mar (
      .clk(clk), .rst_n(rst_n), .ld(ctl.mar_in), .d(bus), .q(mar));
   sb_reg #(.W(W)) u_mdr (
      .clk(clk), .rst_n(rst_n), .ld(mem_done && pend), .d(mem_rdata), .q(mdr));

   for (genvar i = 0; i < NREG; i++) begin : g_gpr
      sb_reg #(.W(W), .RST(GPR_INIT[i*W +: W])) u_r (
         .clk(clk), .rst_n(rst_n), .ld(ctl.g_in[i]), .d(bus), .q(gpr[i]));
      assign gpr_o[i*W +: W] = gpr[i];
   end

   assign off_x = {{(W-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};

   always_comb begin
      bus = '0;
      if (ctl.pc_out)  bus = bus | pc;
      if (ctl.zout)    bus = bus | z;
      if (ctl.mdr_out) bus = bus | mdr;
      if (ctl.off_out) bus = bus | off_x;
      for (int i = 0; i < NREG; i++)
         if (ctl.g_out[i]) bus = bus | gpr[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        pend <= 1'b0;
      else if (ctl.rd)   pend <= 1'b1;
      else if (mem_done) pend <= 1'b0;
   end

   assign mem_req  = pend;
   assign mem_addr = mar;
   assign pc_o     = pc;
   assign ir_o     = ir;

   p_one_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl.pc_out, ctl.zout, ctl.mdr_out, ctl.off_out, ctl.g_out}));
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> mem_req);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done |=> !instr_done);
   p_ir_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(ir) |-> $past(ctl.ir_in));
endmodule

// File: tb/test_sbus_core.sv
module test_sbus_core;
   localparam int W = 32;
   localparam logic [4*W-1:0] INIT = {32'h0000_00F0, 32'h0000_0022, 32'h0000_0003, 32'h0000_0011};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [W-1:0]   mem_addr, mem_rdata = '0, pc_o, ir_o;
   logic           mem_req, mem_done = 1'b0, instr_done;
   logic [4*W-1:0] gpr_o;

   always #2 clk = ~clk;

   sbus_core #(.W(W), .GPR_INIT(INIT)) i_sbus_core (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_req(mem_req),
      .mem_rdata(mem_rdata), .mem_done(mem_done), .instr_done(instr_done),
      .pc_o(pc_o), .ir_o(ir_o), .gpr_o(gpr_o));

   int nchk = 0, nfail = 0;
   logic [31:0] mem [64];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      logic [31:0] pc_m, r1_m, ir_m, ex;
      int cyc, extra, req_n, lat, waitn, ndone, wd;
      bit prev_done, open_req;
      foreach (mem[i]) mem[i] = 32'h7000_0000;
      mem[0]  = 32'h0000_0000;   // add indirect
      mem[1]  = 32'h0000_0000;   // add indirect
      mem[2]  = 32'h1000_0008;   // branch +8
      mem[5]  = 32'h7000_0000;   // unknown opcode
      mem[6]  = 32'h1000_FFE8;   // branch -24
      mem[60] = 32'h0000_0005;   // operand at R3
      pc_m = 0; r1_m = 32'h3;
      cyc = 0; extra = 0; req_n = 0; lat = 1; waitn = 0; ndone = 0; wd = 0;
      prev_done = 0; open_req = 0;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pc_o == 0, "R1 pc", pc_o, 0);
      chk(gpr_o == INIT, "R1 gpr", gpr_o[31:0], INIT[31:0]);
      chk(!mem_req && !instr_done, "R1 req/done", {30'b0, mem_req, instr_done}, 0);
      rst_n = 1'b1;

      while (ndone < 30 && wd < 20000) begin
         @(negedge clk);
         wd++; cyc++;
         mem_done = 1'b0;
         // R9: pulse is one cycle wide
         if (prev_done) chk(!instr_done, "R9 pulse width", {31'b0, instr_done}, 0);
         prev_done = instr_done;
         if (instr_done) begin
            ir_m = mem[pc_m[7:2]];
            pc_m = pc_m + 4;
            if (ir_m[31:28] == 4'd0) begin
               r1_m = r1_m + mem[8'hF0 >> 2];
               ex = 7;
            end else if (ir_m[31:28] == 4'd1) begin
               pc_m = pc_m + {{16{ir_m[15]}}, ir_m[15:0]};
               ex = 5;
            end else ex = 4;
            ex = ex + extra;
            chk(ir_o == ir_m, "R3 ir", ir_o, ir_m);
            chk(pc_o == pc_m, "R3/R5 pc", pc_o, pc_m);
            chk(gpr_o[63:32] == r1_m, "R2/R4 r1", gpr_o[63:32], r1_m);
            chk(gpr_o[31:0] == INIT[31:0] && gpr_o[127:64] == INIT[127:64],
                "R10 r0/r2/r3", gpr_o[31:0], INIT[31:0]);
            chk(cyc == ex, "R4/R5/R6/R7 cycles", cyc, ex);
            cyc = 0; extra = 0; ndone++;
         end
         // memory model
         if (open_req) chk(mem_req, "R8 req dropped", {31'b0, mem_req}, 1);
         if (mem_req) begin
            waitn++;
            if (waitn == lat) begin
               mem_done  = 1'b1;
               mem_rdata = mem[mem_addr[7:2]];
               extra     = extra + lat - 1;
               req_n++;
               lat   = ((req_n * 3) % 4) + 1;
               waitn = 0;
               open_req = 0;
            end else open_req = 1;
         end
      end
      chk(wd < 20000, "watchdog", wd, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule